// File: doc/BRIEF.md
# Two-Bit Cursor Overlay

The block lays a 32-pixel-wide pointer image, two bits per pixel, over a display pixel stream that carries two pixels per tick. The image for each line is fetched as eight bytes over a byte stream at the start of every line on which the vertical cursor window is open. The fetch address is seeded once per frame from a programmed base and steps forward by eight on each such line.

The horizontal placement is programmed in single-pixel units, while the horizontal position arrives in units of two pixels. On the tick whose pixel pair covers the programmed position, the cursor pixel index is set to a negative offset that models a fixed five-pixel delay. After that it steps by two per tick. Cursor code zero lets the display pixel through. Codes one to three replace it with one of three cursor colours. Replacement happens only while the incoming pixels belong to the display or border region.

The image byte stream uses valid/ready. `img_ready` is high only while the current line's eight bytes are still owed. A byte transfers on any clock where `img_valid` and `img_ready` are both high, and the source may stall at will. The pixel stream has no back-pressure, because the display consumes one pixel pair per tick at a fixed rate. `pix_valid` marks a tick, and `line_start` must never coincide with one.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted, and right after it, `out_valid`, `img_ready`, `fetch_addr`, `out_pix0` and `out_pix1` are zero, and the cursor index is inactive.
- R2: `frame_start` loads the image base from `cur_base`. Each `line_start` with `win_active` high presents the current image address on `fetch_addr` on the next clock and steps the address by 8. If `frame_start` comes in the same cycle, the new base is used for that line. A `line_start` with `win_active` low leaves `fetch_addr` unchanged and starts no fetch.
- R3: From the clock after an active `line_start`, `img_ready` stays high until exactly 8 bytes have transferred, then drops. Transferred byte k holds cursor pixels 4k to 4k+3, with pixel 4k+j in bits [2j+1:2j] (least significant pair first). A byte offered while `img_ready` is low changes nothing.
- R4: On a tick with `win_active` high and `hpos == hstart >> 1`, the cursor index for that tick becomes `hstart - 2*hpos - 5`, which is -5 for an even `hstart` and -4 for an odd one.
- R5: `line_start` makes the index inactive (32). On every other tick the index advances by 2 and saturates at 32. A line on which no trigger occurs shows no cursor.
- R6: Output lane 0 shows cursor pixel i when 0 <= i < 32. Lane 1 shows pixel i+1 when -1 <= i < 31. Outside those ranges the lane passes its input through.
- R7: A cursor pixel code of 0 passes the input pixel through. Codes 1, 2 and 3 output `col1`, `col2` and `col3` respectively.
- R8: When `pix_in_region` is low, both lanes pass their inputs through unchanged, while the index still advances.
- R9: `out_valid`, `out_pix0` and `out_pix1` are registered one clock after the `pix_valid` tick they belong to.
- R10: A tick with `win_active` low never triggers the cursor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse that loads the image base for a new frame |
| line_start | input | 1 | Pulse at the start of each line, never together with `pix_valid` |
| win_active | input | 1 | Vertical cursor window open on this line |
| cur_base | input | ADDR_W (20) | Image base address for the frame |
| fetch_addr | output | ADDR_W (20) | Address of the image bytes being fetched for this line |
| img_valid | input | 1 | Image byte offered |
| img_ready | output | 1 | Image byte accepted this clock if valid |
| img_data | input | 8 | Image byte |
| hpos | input | HPOS_W (10) | Horizontal position in pixel pairs |
| hstart | input | HPOS_W+1 (11) | Programmed cursor start in pixels |
| col1 | input | PIX_W (12) | Colour for cursor code 1 |
| col2 | input | PIX_W (12) | Colour for cursor code 2 |
| col3 | input | PIX_W (12) | Colour for cursor code 3 |
| pix_valid | input | 1 | Pixel pair tick |
| pix_in_region | input | 1 | Pixels belong to the display or border region |
| pix_in0 | input | PIX_W (12) | First incoming pixel |
| pix_in1 | input | PIX_W (12) | Second incoming pixel |
| out_valid | output | 1 | Output pair valid |
| out_pix0 | output | PIX_W (12) | First output pixel |
| out_pix1 | output | PIX_W (12) | Second output pixel |

## Verification
The hardest cases to reach are the negative cursor indices right after the trigger. There, lane 1 already shows cursor pixel 0 while lane 0 still passes through, and the even/odd parity of the programmed start picks between two offsets. The bench reaches them with one line per chosen start value: even, odd, zero, and near the right edge of a short 40-tick line. Each tick's expected pair is recomputed from the trigger arithmetic and the image bytes the bench itself transferred. Region gaps during the cursor span, a stalled byte stream, and an extra byte offered after the eighth are mixed into the same sweep.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  // bits per cursor pixel and number of non-transparent codes
  localparam int BPP     = 2;
  localparam int NCOLOUR = (1 << BPP) - 1;
  localparam int BYTE_W  = 8;

  typedef logic [BPP-1:0] ccode_t;
endpackage

// File: rtl/cursor_image_fetch.sv
module cursor_image_fetch
  import cursor_ovl_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int CUR_PIX = 32,
  localparam int IMG_W  = CUR_PIX * BPP,
  localparam int NBYTES = IMG_W / BYTE_W,
  localparam int CNT_W  = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              win_active,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [IMG_W-1:0]  image
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(NBYTES);

  logic [ADDR_W-1:0] next_addr;
  logic [ADDR_W-1:0] fetch_q;
  logic [CNT_W-1:0]  cnt;
  logic              loading;
  logic              take;
  logic [ADDR_W-1:0] line_base;

  assign line_base  = frame_start ? base : next_addr;
  assign take       = loading && byte_valid;
  assign byte_ready = loading;
  assign fetch_addr = fetch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_addr <= '0;
      fetch_q   <= '0;
      cnt       <= '0;
      loading   <= 1'b0;
    end else if (line_start && win_active) begin
      fetch_q   <= line_base;
      next_addr <= line_base + STEP;
      cnt       <= '0;
      loading   <= 1'b1;
    end else begin
      if (frame_start) next_addr <= base;
      if (take) begin
        cnt <= cnt + CNT_W'(1);
        if (cnt == CNT_W'(NBYTES - 1)) loading <= 1'b0;
      end
    end
  end

  // one holding register per image byte, written in arrival order
  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            byte_q <= '0;
      else if (take && cnt == CNT_W'(k))     byte_q <= byte_data;
    end
    assign image[k*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/cursor_index_track.sv
module cursor_index_track #(
  parameter int HPOS_W  = 10,
  parameter int CUR_PIX = 32,
  parameter int DELAY   = 5,
  parameter int STEP    = 2,
  parameter int IDX_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    line_start,
  input  logic                    tick,
  input  logic                    win_active,
  input  logic [HPOS_W-1:0]       hpos,
  input  logic [HPOS_W:0]         hstart,
  output logic signed [IDX_W-1:0] idx_now
);
  localparam logic signed [IDX_W-1:0] INACTIVE = IDX_W'(CUR_PIX);
  localparam logic signed [IDX_W-1:0] ADV      = IDX_W'(STEP);
  localparam logic signed [IDX_W-1:0] DLY      = IDX_W'(DELAY);

  logic signed [IDX_W-1:0] idx_q;
  logic signed [IDX_W-1:0] half_off;
  logic signed [IDX_W-1:0] idx_trig;
  logic signed [IDX_W-1:0] idx_adv;
  logic                    trig;

  // pair position 2*hpos covers hstart when hstart - 2*hpos is 0 or 1,
  // i.e. when the upper bits of hstart equal hpos
  assign trig     = win_active && (hstart[HPOS_W:1] == hpos);
  assign half_off = $signed({{(IDX_W-1){1'b0}}, hstart[0]});
  assign idx_trig = half_off - DLY;
  assign idx_adv  = (idx_q >= INACTIVE) ? INACTIVE : idx_q + ADV;
  assign idx_now  = trig ? idx_trig : idx_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= INACTIVE;
    else if (line_start) idx_q <= INACTIVE;
    else if (tick)       idx_q <= idx_now;
  end
endmodule

// File: rtl/cursor_lane_mux.sv
module cursor_lane_mux
  import cursor_ovl_pkg::*;
#(
  parameter int PIX_W   = 12,
  parameter int CUR_PIX = 32,
  parameter int IDX_W   = 8,
  localparam int IMG_W  = CUR_PIX * BPP,
  localparam int PW     = $clog2(CUR_PIX)
) (
  input  logic [IMG_W-1:0]               image,
  input  logic signed [IDX_W-1:0]        idx,
  input  logic                           region,
  input  logic [PIX_W-1:0]               pix_in,
  input  logic [NCOLOUR-1:0][PIX_W-1:0]  colours,
  output logic [PIX_W-1:0]               pix_out
);
  logic          in_rng;
  logic [PW-1:0] idx_u;
  ccode_t        code;
  ccode_t        slot;

  assign in_rng  = (idx >= 0) && (idx < CUR_PIX);
  assign idx_u   = idx[PW-1:0];
  assign code    = in_rng ? image[idx_u*BPP +: BPP] : '0;
  assign slot    = code - ccode_t'(1);
  assign pix_out = (region && code != '0) ? colours[slot] : pix_in;
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_ovl_pkg::*;
#(
  parameter int PIX_W   = 12,
  parameter int ADDR_W  = 20,
  parameter int HPOS_W  = 10,
  parameter int CUR_PIX = 32,
  parameter int DELAY   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              win_active,
  input  logic [ADDR_W-1:0] cur_base,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              img_valid,
  output logic              img_ready,
  input  logic [7:0]        img_data,
  input  logic [HPOS_W-1:0] hpos,
  input  logic [HPOS_W:0]   hstart,
  input  logic [PIX_W-1:0]  col1,
  input  logic [PIX_W-1:0]  col2,
  input  logic [PIX_W-1:0]  col3,
  input  logic              pix_valid,
  input  logic              pix_in_region,
  input  logic [PIX_W-1:0]  pix_in0,
  input  logic [PIX_W-1:0]  pix_in1,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix0,
  output logic [PIX_W-1:0]  out_pix1
);
  localparam int LANES = 2;
  localparam int IMG_W = CUR_PIX * BPP;
  localparam int IDX_W = $clog2(CUR_PIX + LANES) + 2;

  logic [IMG_W-1:0]              image;
  logic signed [IDX_W-1:0]       idx_now;
  logic [NCOLOUR-1:0][PIX_W-1:0] colours;
  logic [PIX_W-1:0]              lane_in  [LANES];
  logic [PIX_W-1:0]              lane_out [LANES];
  logic [PIX_W-1:0]              lane_q   [LANES];
  logic                          valid_q;

  assign colours    = {col3, col2, col1};
  assign lane_in[0] = pix_in0;
  assign lane_in[1] = pix_in1;

  cursor_image_fetch #(
    .ADDR_W (ADDR_W),
    .CUR_PIX(CUR_PIX)
  ) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .line_start (line_start),
    .win_active (win_active),
    .base       (cur_base),
    .fetch_addr (fetch_addr),
    .byte_valid (img_valid),
    .byte_ready (img_ready),
    .byte_data  (img_data),
    .image      (image)
  );

  cursor_index_track #(
    .HPOS_W (HPOS_W),
    .CUR_PIX(CUR_PIX),
    .DELAY  (DELAY),
    .STEP   (LANES),
    .IDX_W  (IDX_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .tick      (pix_valid),
    .win_active(win_active),
    .hpos      (hpos),
    .hstart    (hstart),
    .idx_now   (idx_now)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [IDX_W-1:0] lane_idx;
    assign lane_idx = idx_now + $signed(IDX_W'(l));

    cursor_lane_mux #(
      .PIX_W  (PIX_W),
      .CUR_PIX(CUR_PIX),
      .IDX_W  (IDX_W)
    ) u_mux (
      .image  (image),
      .idx    (lane_idx),
      .region (pix_in_region),
      .pix_in (lane_in[l]),
      .colours(colours),
      .pix_out(lane_out[l])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lane_q[l] <= '0;
      else if (pix_valid) lane_q[l] <= lane_out[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= pix_valid;
  end

  assign out_valid = valid_q;
  assign out_pix0  = lane_q[0];
  assign out_pix1  = lane_q[1];
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int PIX_W  = 12,
  parameter int ADDR_W = 20,
  parameter int HPOS_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_start,
  input logic              win_active,
  input logic [ADDR_W-1:0] cur_base,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              img_valid,
  input logic              img_ready,
  input logic [HPOS_W-1:0] hpos,
  input logic [HPOS_W:0]   hstart,
  input logic              pix_valid,
  input logic              pix_in_region,
  input logic [PIX_W-1:0]  pix_in0,
  input logic [PIX_W-1:0]  pix_in1,
  input logic              out_valid,
  input logic [PIX_W-1:0]  out_pix0,
  input logic [PIX_W-1:0]  out_pix1
);
  localparam int NB = 8;

  logic [4:0] acc_cnt;
  logic       trig_seen;
  logic       trig_here;

  assign trig_here = pix_valid && win_active && (hstart[HPOS_W:1] == hpos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt   <= '0;
      trig_seen <= 1'b0;
    end else begin
      if (line_start && win_active)                   acc_cnt <= '0;
      else if (img_valid && img_ready && acc_cnt < 31) acc_cnt <= acc_cnt + 5'd1;
      if (line_start)     trig_seen <= 1'b0;
      else if (trig_here) trig_seen <= 1'b1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !img_ready && fetch_addr == '0));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  a_r3_ready_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready |-> acc_cnt < NB);

  a_r2_frame_base_used: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && line_start && win_active) |=> fetch_addr == $past(cur_base));

  a_r8_outside_region: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_in_region) |=>
      (out_pix0 == $past(pix_in0) && out_pix1 == $past(pix_in1)));

  a_r5_untriggered_line: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_start && !trig_seen && !trig_here) |=>
      (out_pix0 == $past(pix_in0) && out_pix1 == $past(pix_in1)));
endmodule

bind cursor_overlay cursor_overlay_chk #(
  .PIX_W (PIX_W),
  .ADDR_W(ADDR_W),
  .HPOS_W(HPOS_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_start  (frame_start),
  .line_start   (line_start),
  .win_active   (win_active),
  .cur_base     (cur_base),
  .fetch_addr   (fetch_addr),
  .img_valid    (img_valid),
  .img_ready    (img_ready),
  .hpos         (hpos),
  .hstart       (hstart),
  .pix_valid    (pix_valid),
  .pix_in_region(pix_in_region),
  .pix_in0      (pix_in0),
  .pix_in1      (pix_in1),
  .out_valid    (out_valid),
  .out_pix0     (out_pix0),
  .out_pix1     (out_pix1)
);

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W  = 12;
  localparam int ADDR_W = 20;
  localparam int HPOS_W = 10;
  localparam int NH     = 40;
  localparam int NLINES = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              frame_start, line_start, win_active;
  logic [ADDR_W-1:0] cur_base, fetch_addr;
  logic              img_valid, img_ready;
  logic [7:0]        img_data;
  logic [HPOS_W-1:0] hpos;
  logic [HPOS_W:0]   hstart;
  logic [PIX_W-1:0]  col1, col2, col3;
  logic              pix_valid, pix_in_region;
  logic [PIX_W-1:0]  pix_in0, pix_in1;
  logic              out_valid;
  logic [PIX_W-1:0]  out_pix0, out_pix1;

  cursor_overlay uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .win_active(win_active), .cur_base(cur_base), .fetch_addr(fetch_addr),
    .img_valid(img_valid), .img_ready(img_ready), .img_data(img_data),
    .hpos(hpos), .hstart(hstart), .col1(col1), .col2(col2), .col3(col3),
    .pix_valid(pix_valid), .pix_in_region(pix_in_region),
    .pix_in0(pix_in0), .pix_in1(pix_in1),
    .out_valid(out_valid), .out_pix0(out_pix0), .out_pix1(out_pix1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  logic [7:0] mimg [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gen_byte(input int ln, input int k);
    return 8'((ln * 53 + k * 71 + 13) ^ (k * 9));
  endfunction

  function automatic int code_at(input int i);
    return int'((mimg[i / 4] >> (2 * (i % 4))) & 8'd3);
  endfunction

  function automatic logic [PIX_W-1:0] expect_px(input int i, input bit reg_on,
                                                 input logic [PIX_W-1:0] pin);
    int c;
    if (!reg_on || i < 0 || i >= 32) return pin;
    c = code_at(i);
    if (c == 1) return col1;
    if (c == 2) return col2;
    if (c == 3) return col3;
    return pin;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int hs_tab [NLINES] = '{20, 33, 30, 0, 61};
    logic [ADDR_W-1:0] maddr;
    logic [ADDR_W-1:0] last_fetch;
    int midx;

    rst_n = 1'b0; frame_start = 0; line_start = 0; win_active = 0;
    cur_base = '0; img_valid = 0; img_data = '0; hpos = '0; hstart = '0;
    col1 = 12'hF01; col2 = 12'hF02; col3 = 12'hF03;
    pix_valid = 0; pix_in_region = 0; pix_in0 = '0; pix_in1 = '0;
    for (int k = 0; k < 8; k++) mimg[k] = 8'h00;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    chk(img_ready == 0, "R1", "img_ready in reset", img_ready, 0);
    chk(fetch_addr == 0, "R1", "fetch_addr in reset", fetch_addr, 0);
    chk(out_pix0 == 0 && out_pix1 == 0, "R1", "pixels in reset", out_pix0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cur_base = 20'h01230;
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    maddr = 20'h01230;
    last_fetch = '0;

    for (int ln = 0; ln < NLINES; ln++) begin
      bit win;
      int hs;
      win = (ln != 2);
      hs  = hs_tab[ln];
      hstart = 11'(hs);
      win_active = win;
      line_start = 1;
      @(negedge clk);
      line_start = 0;
      midx = 32;
      if (win) begin
        chk(fetch_addr == maddr, "R2", "line fetch address", fetch_addr, maddr);
        last_fetch = maddr;
        maddr = maddr + 20'd8;
        chk(img_ready == 1, "R3", "ready after active line start", img_ready, 1);
        begin
          int k;
          int cyc;
          k = 0;
          cyc = 0;
          while (k < 8) begin
            bit acc;
            img_valid = ((cyc % 3) != 1);
            img_data  = gen_byte(ln, k);
            acc = img_valid && img_ready;
            if (acc) mimg[k] = img_data;
            @(negedge clk);
            if (acc) k++;
            cyc++;
          end
          img_valid = 1;
          img_data  = 8'hFF;
          chk(img_ready == 0, "R3", "ready after eight bytes", img_ready, 0);
          @(negedge clk);
          img_valid = 0;
        end
      end else begin
        chk(fetch_addr == last_fetch, "R2", "address held on closed line", fetch_addr, last_fetch);
        chk(img_ready == 0, "R3", "no fetch on closed line", img_ready, 0);
      end

      for (int h = 0; h < NH; h++) begin
        bit trig;
        bit reg_on;
        logic [PIX_W-1:0] p0, p1, e0, e1;
        string t0, t1;
        reg_on = !(h < 2 || (h >= 14 && h < 16));
        p0 = {2'b10, 4'(ln), 6'(h)};
        p1 = {2'b01, 4'(ln), 6'(h)};
        trig = win && (h == hs / 2);
        if (trig) midx = hs - 2 * h - 5;
        else if (midx >= 32) midx = 32;
        else midx = midx + 2;
        e0 = expect_px(midx, reg_on, p0);
        e1 = expect_px(midx + 1, reg_on, p1);
        // requirement tags chosen by the situation under test
        if (!reg_on)      begin t0 = "R8";  t1 = "R8";  end
        else if (!win)    begin t0 = "R10"; t1 = "R10"; end
        else if (trig)    begin t0 = "R4";  t1 = "R4";  end
        else if (midx >= 32) begin t0 = "R5"; t1 = "R5"; end
        else begin
          t0 = (e0 != p0) ? "R7" : "R6";
          t1 = (e1 != p1) ? "R7" : "R6";
        end
        hpos = 10'(h);
        pix_in_region = reg_on;
        pix_in0 = p0;
        pix_in1 = p1;
        pix_valid = 1;
        @(negedge clk);
        pix_valid = 0;
        chk(out_valid == 1, "R9", "out_valid after tick", out_valid, 1);
        chk(out_pix0 == e0, t0, "lane 0 pixel", out_pix0, e0);
        chk(out_pix1 == e1, t1, "lane 1 pixel", out_pix1, e1);
        @(negedge clk);
        chk(out_valid == 0, "R9", "out_valid idle", out_valid, 0);
      end
    end

    // R2: frame start together with an active line start uses the new base
    cur_base = 20'h0A000;
    frame_start = 1;
    line_start = 1;
    win_active = 1;
    @(negedge clk);
    frame_start = 0;
    line_start = 0;
    chk(fetch_addr == 20'h0A000, "R2", "new base on combined start", fetch_addr, 20'h0A000);
    win_active = 1;
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    chk(fetch_addr == 20'h0A008, "R2", "step after new base", fetch_addr, 20'h0A008);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule